// File: doc/BRIEF.md
# Framed Serial Command Front End

This block is the serial receive and transmit stage in front of the command decoder of a digitally controlled rheostat. A host drives an active-low frame strobe, a serial clock that idles low and a data line. Bits are taken MSB first on each falling serial-clock edge. When the frame strobe rises, the last 16 bits received are handed to the decoder as one word, but only when the bit count is a nonzero whole multiple of 16. All serial inputs are oversampled by a system clock at least four times faster than the serial clock. They pass through two-flop synchronizers with edge detection, so the block lives entirely in the system clock domain.

The open-drain output either pulls low or lets go. During a frame it presents the shift register MSB, updated on each rising serial-clock edge. At frame start the register is cleared, or loaded with a readback word that the decoder posted after the previous command. The first 16 output bit times therefore carry the readback word, or zeros, and later bit times repeat the input 16 bits late, which makes daisy chains work. A key word followed directly by a no-op word disables the output driver. While the decoder reports a long store operation in progress, completed frames are thrown away.

Top module: `rsf_top`

## Requirements
- R1: During and after reset, word_valid_o is low, word_o is zero and sdo_pull_o is low.
- R2: A frame of exactly 16 falling serial-clock edges delivers the captured bits (first bit = word bit 15) on word_o with a one-cycle word_valid_o pulse after the frame strobe rises; word_o holds between pulses.
- R3: A frame of 32 or 48 clocks delivers only the last 16 bits received.
- R4: A frame whose clock count is not a nonzero multiple of 16 (15, 31, 33) produces no pulse.
- R5: An accepted word whose bits 15:14 are not both zero is not forwarded (the key word 0x8001 excepted, see R10).
- R6: Output bit k of a frame (k counted from 1, changed on rising serial-clock edges) is the pending readback bit 16-k for k up to 16 (zero if none), and input bit k-16 beyond that.
- R7: A word posted with rdbk_load_i is shifted out MSB first in the first 16 bit times of the next frame only.
- R8: sdo_pull_o is low whenever no frame is in progress.
- R9: A frame that completes while busy_lock_i is high produces no pulse.
- R10: Accepted word 0x8001 is not forwarded; if the next accepted word is 0x0000 (forwarded as usual), sdo_pull_o stays low in all later frames until a nonzero word is forwarded.
- R11: Word 0x8001 followed by any accepted word other than 0x0000 leaves the output driver enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x the serial clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock, idles low |
| fsync_ni | input | 1 | Frame strobe, active low |
| sdi_i | input | 1 | Serial data in |
| sdo_pull_o | output | 1 | Open-drain data out: 1 pulls the line low |
| busy_lock_i | input | 1 | Store operation in progress; completed frames are dropped |
| rdbk_load_i | input | 1 | One-cycle strobe posting a readback word |
| rdbk_word_i | input | 16 | Readback word for the next frame |
| word_valid_o | output | 1 | One-cycle pulse: word_o carries a new word |
| word_o | output | 16 | Last accepted word |

## Verification
The checks assume the serial inputs respect the oversampling margin: each serial-clock phase lasts at least two system cycles, data is steady across the falling edge that captures it, and the frame strobe never moves in the same system cycle as a serial-clock edge. The stimulus drives every input on the falling system-clock edge, holds each serial-clock phase for four system cycles, changes data together with the rising serial-clock edge and waits four cycles around each strobe change. The output is read back one full phase after the rising edge, once the three-register path from pin to output has settled.

// File: rtl/rsf_pkg.sv
`timescale 1ns/1ps
package rsf_pkg;
  localparam int unsigned WORD_W   = 16;
  localparam int unsigned HDR_W    = 2;
  localparam int unsigned SYNC_LEN = 2;
  localparam logic [WORD_W-1:0] HIZ_KEY  = 16'h8001;
  localparam logic [WORD_W-1:0] NOP_WORD = 16'h0000;
endpackage

// File: rtl/rsf_sync.sv
`timescale 1ns/1ps
module rsf_sync #(
  parameter int unsigned        W       = 1,
  parameter int unsigned        STAGES  = 2,
  parameter logic [W-1:0]       RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/rsf_frame.sv
`timescale 1ns/1ps
module rsf_frame #(
  parameter int unsigned WORD_W = rsf_pkg::WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fs_fall_i,
  input  logic              fs_rise_i,
  input  logic              sclk_fall_i,
  input  logic              sclk_rise_i,
  input  logic              sdi_i,
  input  logic [WORD_W-1:0] preload_i,
  output logic              act_o,
  output logic              done_o,
  output logic              whole_o,
  output logic [WORD_W-1:0] sr_o,
  output logic              bit_o
);
  localparam int unsigned     CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic              act_q, full_q, bit_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      full_q <= 1'b0;
      bit_q  <= 1'b1;
      cnt_q  <= '0;
      sr_q   <= '0;
    end else if (fs_fall_i) begin
      act_q  <= 1'b1;
      full_q <= 1'b0;
      bit_q  <= 1'b1;
      cnt_q  <= '0;
      sr_q   <= preload_i;
    end else if (fs_rise_i) begin
      act_q  <= 1'b0;
    end else if (act_q) begin
      if (sclk_fall_i) begin
        sr_q <= {sr_q[WORD_W-2:0], sdi_i};
        if (cnt_q == LAST) begin
          cnt_q  <= '0;
          full_q <= 1'b1;
        end else begin
          cnt_q  <= cnt_q + 1'b1;
        end
      end
      if (sclk_rise_i) bit_q <= sr_q[WORD_W-1];
    end
  end

  assign act_o   = act_q;
  assign done_o  = fs_rise_i & act_q;
  assign whole_o = full_q & (cnt_q == '0);
  assign sr_o    = sr_q;
  assign bit_o   = bit_q;
endmodule

// File: rtl/rsf_filter.sv
`timescale 1ns/1ps
module rsf_filter #(
  parameter int unsigned       WORD_W = rsf_pkg::WORD_W,
  parameter int unsigned       HDR_W  = rsf_pkg::HDR_W,
  parameter logic [WORD_W-1:0] KEY    = rsf_pkg::HIZ_KEY,
  parameter logic [WORD_W-1:0] NOP    = rsf_pkg::NOP_WORD
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic              whole_i,
  input  logic              busy_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] word_o,
  output logic              hiz_o
);
  logic              accept, hdr_ok;
  logic              valid_q, arm_q, hiz_q;
  logic [WORD_W-1:0] word_q;

  assign accept = done_i & whole_i & ~busy_i;
  assign hdr_ok = (word_i[WORD_W-1 -: HDR_W] == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      arm_q   <= 1'b0;
      hiz_q   <= 1'b0;
      word_q  <= '0;
    end else begin
      valid_q <= 1'b0;
      if (accept) begin
        if (word_i == KEY) begin
          arm_q <= 1'b1;
        end else begin
          arm_q <= 1'b0;
          if (hdr_ok) begin
            valid_q <= 1'b1;
            word_q  <= word_i;
            if (word_i == NOP) begin
              if (arm_q) hiz_q <= 1'b1;
            end else begin
              hiz_q <= 1'b0;
            end
          end
        end
      end
    end
  end

  assign valid_o = valid_q;
  assign word_o  = word_q;
  assign hiz_o   = hiz_q;
endmodule

// File: rtl/rsf_top.sv
`timescale 1ns/1ps
module rsf_top #(
  parameter int unsigned WORD_W   = rsf_pkg::WORD_W,
  parameter int unsigned SYNC_LEN = rsf_pkg::SYNC_LEN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              fsync_ni,
  input  logic              sdi_i,
  output logic              sdo_pull_o,
  input  logic              busy_lock_i,
  input  logic              rdbk_load_i,
  input  logic [WORD_W-1:0] rdbk_word_i,
  output logic              word_valid_o,
  output logic [WORD_W-1:0] word_o
);
  // {sclk, fsync_n, sdi}; strobe idles high
  logic [2:0] pin_s;
  logic       sclk_d, fs_d;
  logic       sclk_rise, sclk_fall, fs_rise, fs_fall;

  rsf_sync #(.W(3), .STAGES(SYNC_LEN), .RST_VAL(3'b010)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sclk_i, fsync_ni, sdi_i}),
    .q_o   (pin_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d <= 1'b0;
      fs_d   <= 1'b1;
    end else begin
      sclk_d <= pin_s[2];
      fs_d   <= pin_s[1];
    end
  end

  assign sclk_rise =  pin_s[2] & ~sclk_d;
  assign sclk_fall = ~pin_s[2] &  sclk_d;
  assign fs_rise   =  pin_s[1] & ~fs_d;
  assign fs_fall   = ~pin_s[1] &  fs_d;

  // readback word held until the next frame starts
  logic              pend_v_q;
  logic [WORD_W-1:0] pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_v_q <= 1'b0;
      pend_q   <= '0;
    end else if (rdbk_load_i) begin
      pend_v_q <= 1'b1;
      pend_q   <= rdbk_word_i;
    end else if (fs_fall) begin
      pend_v_q <= 1'b0;
    end
  end

  logic              frame_act, frame_done, frame_whole, sdo_bit, hiz_q;
  logic [WORD_W-1:0] frame_sr;

  rsf_frame #(.WORD_W(WORD_W)) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fs_fall_i  (fs_fall),
    .fs_rise_i  (fs_rise),
    .sclk_fall_i(sclk_fall),
    .sclk_rise_i(sclk_rise),
    .sdi_i      (pin_s[0]),
    .preload_i  (pend_v_q ? pend_q : '0),
    .act_o      (frame_act),
    .done_o     (frame_done),
    .whole_o    (frame_whole),
    .sr_o       (frame_sr),
    .bit_o      (sdo_bit)
  );

  rsf_filter #(.WORD_W(WORD_W)) u_filter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .done_i (frame_done),
    .whole_i(frame_whole),
    .busy_i (busy_lock_i),
    .word_i (frame_sr),
    .valid_o(word_valid_o),
    .word_o (word_o),
    .hiz_o  (hiz_q)
  );

  assign sdo_pull_o = frame_act & ~hiz_q & ~sdo_bit;
endmodule

// File: rtl/rsf_checker.sv
`timescale 1ns/1ps
module rsf_checker #(
  parameter int unsigned WORD_W = rsf_pkg::WORD_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_lock_i,
  input logic              word_valid_i,
  input logic [WORD_W-1:0] word_i,
  input logic              sdo_pull_i,
  input logic              frame_act_i,
  input logic              hiz_i
);
  p_pulse_one_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_i |=> !word_valid_i);

  p_word_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_valid_i |-> $stable(word_i));

  p_hdr_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_i |-> (word_i[WORD_W-1 -: 2] == 2'b00));

  p_idle_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_act_i |-> !sdo_pull_i);

  p_busy_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_i |-> !$past(busy_lock_i));

  p_hiz_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hiz_i |-> !sdo_pull_i);
endmodule

bind rsf_top rsf_checker #(.WORD_W(WORD_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_lock_i (busy_lock_i),
  .word_valid_i(word_valid_o),
  .word_i      (word_o),
  .sdo_pull_i  (sdo_pull_o),
  .frame_act_i (frame_act),
  .hiz_i       (hiz_q)
);

// File: tb/rsf_top_tb_top.sv
`timescale 1ns/1ps
module rsf_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0, fsync_n = 1'b1, sdi = 1'b0;
  logic        busy = 1'b0, rd_load = 1'b0;
  logic [15:0] rd_word = '0;
  logic        sdo_pull, wvalid;
  logic [15:0] wout;

  int nchk = 0, nfail = 0, vcnt = 0;
  logic [15:0] last_word = '0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  rsf_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .fsync_ni(fsync_n), .sdi_i(sdi),
    .sdo_pull_o(sdo_pull), .busy_lock_i(busy), .rdbk_load_i(rd_load),
    .rdbk_word_i(rd_word), .word_valid_o(wvalid), .word_o(wout)
  );

  always @(negedge clk) if (wvalid) begin
    vcnt++;
    last_word = wout;
  end

  typedef struct packed {
    logic [7:0]  nbits;
    logic [47:0] data;
    logic        ok;
    logic [15:0] word;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{8'd16, 48'h0000_0000_0555, 1'b1, 16'h0555},  // R2
    '{8'd32, 48'h0000_1234_0ABC, 1'b1, 16'h0ABC},  // R3
    '{8'd48, 48'h0001_0002_03FF, 1'b1, 16'h03FF},  // R3
    '{8'd15, 48'h0000_0000_0555, 1'b0, 16'h0000},  // R4
    '{8'd31, 48'h0000_1234_0ABC, 1'b0, 16'h0000},  // R4
    '{8'd33, 48'h0001_1234_0ABC, 1'b0, 16'h0000},  // R4
    '{8'd16, 48'h0000_0000_C123, 1'b0, 16'h0000},  // R5
    '{8'd16, 48'h0000_0000_4000, 1'b0, 16'h0000}   // R5
  };

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_frame(input logic [47:0] data, input int n, output logic [47:0] seen);
    seen = '0;
    fsync_n = 1'b0;
    wait_clk(4);
    for (int i = n - 1; i >= 0; i--) begin
      sdi  = data[i];
      sclk = 1'b1;
      wait_clk(4);
      seen = {seen[46:0], ~sdo_pull};
      sclk = 1'b0;
      wait_clk(4);
    end
    fsync_n = 1'b1;
    wait_clk(8);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    logic [47:0] seen;
    int pre;
    wait_clk(3);
    chk("R1 valid", wvalid, 0);
    chk("R1 pull", sdo_pull, 0);
    chk("R1 word", wout, 0);
    rst_n = 1'b1;
    wait_clk(4);
    chk("R1 after release", {wvalid, sdo_pull, wout}, 0);

    for (int v = 0; v < NV; v++) begin
      pre = vcnt;
      run_frame(VECS[v].data, int'(VECS[v].nbits), seen);
      chk($sformatf("R2/R3/R4/R5 count v%0d", v), vcnt - pre, VECS[v].ok ? 1 : 0);
      if (VECS[v].ok) chk($sformatf("R2/R3 word v%0d", v), last_word, VECS[v].word);
      chk($sformatf("R6 sdo v%0d", v), seen, VECS[v].data >> 16);
      chk($sformatf("R8 idle v%0d", v), sdo_pull, 0);
    end

    // R7 readback in next frame only
    rd_word = 16'h02A5; rd_load = 1'b1;
    wait_clk(1);
    rd_load = 1'b0;
    wait_clk(2);
    chk("R8 idle with pending", sdo_pull, 0);
    run_frame(48'h0, 16, seen);
    chk("R7 readback out", seen, 48'h02A5);
    run_frame(48'h0, 16, seen);
    chk("R7 only once", seen, 48'h0);
    rd_word = 16'h0133; rd_load = 1'b1;
    wait_clk(1);
    rd_load = 1'b0;
    run_frame(48'h0000_00F0_0000, 32, seen);
    chk("R6 readback then chain", seen, 48'h0133_00F0);

    // R9 busy lock
    busy = 1'b1;
    pre = vcnt;
    run_frame(48'h0123, 16, seen);
    chk("R9 dropped", vcnt - pre, 0);
    busy = 1'b0;
    run_frame(48'h0124, 16, seen);
    chk("R9 resumes", {vcnt - pre, last_word}, {32'd1, 16'h0124});

    // R10 key then no-op disables driver
    pre = vcnt;
    run_frame(48'h8001, 16, seen);
    chk("R10 key not forwarded", vcnt - pre, 0);
    run_frame(48'h0000, 16, seen);
    chk("R10 nop forwarded", {vcnt - pre, last_word}, {32'd1, 16'h0000});
    run_frame(48'h0000_0000_0155, 32, seen);
    chk("R10 output released", seen, 48'hFFFF_FFFF);
    chk("R10 word still taken", last_word, 16'h0155);
    run_frame(48'h0000_00AA_0000, 32, seen);
    chk("R10 cleared by nonzero word", seen, 48'h00AA);

    // R11 key followed by another word
    run_frame(48'h8001, 16, seen);
    run_frame(48'h0042, 16, seen);
    chk("R11 word forwarded", last_word, 16'h0042);
    run_frame(48'h0000_0011_0000, 32, seen);
    chk("R11 driver on", seen, 48'h0011);

    finished = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule